// File: doc/BRIEF.md
# Supply Monitor Reset and Low-Voltage Interrupt Controller

This block sits between the comparators of an analog supply monitor and the rest of the chip. It turns a noisy below-reset-threshold comparator output into a clean system reset request. Short supply dips are filtered out by a dwell counter that runs on a free-running low-frequency clock. Once reset is requested, the analog side is switched to its release level through a select output. The reset drops only after the supply has stayed above that level for the same dwell time.

A second comparator, the low-voltage detect, sets a sticky flag. Software clears the flag with a one-cycle strobe. The flag is ANDed with the global interrupt enable to give the interrupt request. A 2-bit option code picks one of three trip and release level pairs, and its fourth value turns the reset function off. Both comparator inputs are asynchronous and pass through a synchronizer before any use.

Top module: `supply_guard`

## Requirements
- R1: After rst_n is released, sys_reset_o, lv_flag_o and lv_irq_o are 0.
- R2: A high level on below_trip_i held for fewer than FILT_CYCLES consecutive clocks never asserts sys_reset_o.
- R3: A high level on below_trip_i held for L >= FILT_CYCLES clocks asserts sys_reset_o. It is first seen high after the clock edge FILT_CYCLES+SYNC_STAGES, counting the first edge that samples the high input as edge 1.
- R4: Once asserted, sys_reset_o stays high until below_trip_i has been low for FILT_CYCLES consecutive clocks. It is therefore high for exactly L cycles in the R3 case. release_sel_o is 1 whenever sys_reset_o is 1 and 0 otherwise.
- R5: level_code_o copies level_opt_i (00: highest levels, 01: middle, 10: lowest). While level_opt_i is 11, sys_reset_o is held 0 whatever the comparators show.
- R6: lv_flag_o becomes 1 after edge SYNC_STAGES+1 of a high below_detect_i, and not before.
- R7: lv_flag_o stays 1 when below_detect_i falls. Only a clock edge with flag_clr_i=1 and no synchronized detect clears it.
- R8: When flag_clr_i=1 and the synchronized detect is high at the same edge, the flag stays 1.
- R9: lv_irq_o is 1 exactly when lv_flag_o is 1 and gie_i is 1.
- R10: While sys_reset_o is 1, lv_flag_o and lv_irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running low-frequency clock |
| rst_n | input | 1 | Synchronous active-low reset |
| below_detect_i | input | 1 | Asynchronous comparator: supply below the detect level |
| below_trip_i | input | 1 | Asynchronous comparator: supply below the selected trip or release level |
| level_opt_i | input | 2 | Reset level option code; 11 disables low-voltage reset |
| gie_i | input | 1 | Global interrupt enable |
| flag_clr_i | input | 1 | Software clear strobe for the flag |
| sys_reset_o | output | 1 | Filtered system reset request |
| level_code_o | output | 2 | Level pair select to the analog side |
| release_sel_o | output | 1 | 1 selects the release level, 0 the trip level |
| lv_flag_o | output | 1 | Sticky low-voltage flag |
| lv_irq_o | output | 1 | Interrupt request |

## Verification
Trip pulses of every length from one clock up to four clocks past the filter length are swept for each enabled level code. The sweep separates a dip that is ignored from one that trips. It also checks the first reset cycle and the exact reset duration, which exposes an off-by-one in the counter or in the synchronizer depth. The same sweep is repeated with the disabling code, where every length must leave reset low. The detect flag is driven through set, hardware fall, clear, and a clear that collides with a set. This sequence separates sticky behaviour from level following and shows the set-over-clear priority. The interrupt gate is tried with the enable both off and on. Detect is kept high during the reset sweeps, so that any flag or interrupt leaking through an active reset is caught.

// File: rtl/supply_guard_pkg.sv
// Package: shared types for the supply monitor controller.
// Assumes the option code is a 2-bit static strap value.
package supply_guard_pkg;

    typedef enum logic [1:0] {
        LVL_HIGH = 2'b00,
        LVL_MID  = 2'b01,
        LVL_LOW  = 2'b10,
        LVL_OFF  = 2'b11
    } lvl_code_e;

    // True when the code turns the low-voltage reset off.
    function automatic logic code_is_off(input lvl_code_e code);
        return code == LVL_OFF;
    endfunction

endpackage

// File: rtl/sg_sync.sv
// Module: sg_sync
// Multi-flop synchronizer for a bundle of asynchronous comparator bits.
// Assumes each bit is independent (no bus coherency is needed).
module sg_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw asynchronous bits.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= async_i;
                end
            end else begin : g_next
                // Shift one stage further down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/sg_dwell_filter.sv
// Module: sg_dwell_filter
// Counts consecutive cycles with cond_i high. It fires expired_o in the
// cycle where the CYCLES-th consecutive high cycle is sampled, then restarts.
// Any low cycle or a held clear returns the count to zero.
// Assumes CYCLES >= 2.
module sg_dwell_filter #(
    parameter int CYCLES = 8,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_clr_i,
    input  logic          cond_i,
    output logic          expired_o,
    output logic [CW-1:0] count_o
);

    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          at_last;

    // Terminal-count decode.
    always_comb begin
        at_last   = (cnt_q == LAST);
        expired_o = cond_i && at_last && !hold_clr_i;
    end

    // Dwell counter: advance while cond holds, restart on any break.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_clr_i || !cond_i) begin
            cnt_q <= '0;
        end else if (at_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/sg_reset_ctrl.sv
// Module: sg_reset_ctrl
// Two-phase reset request. In the armed phase the filter watches for a
// lasting drop below trip. In the held phase it watches for a lasting
// recovery above release. A disabling code forces the armed phase.
// Assumes below_i is already synchronous to clk.
module sg_reset_ctrl
    import supply_guard_pkg::*;
#(
    parameter int FILT_CYCLES = 8,
    localparam int CW         = $clog2(FILT_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          below_i,
    input  lvl_code_e     code_i,
    output logic          reset_req_o,
    output logic          release_phase_o,
    output logic [CW-1:0] dwell_cnt_o
);

    logic held_q;
    logic off;
    logic watch;
    logic fire;

    // Pick the condition the filter must see for a phase change.
    always_comb begin
        off   = code_is_off(code_i);
        watch = held_q ? !below_i : below_i;
    end

    sg_dwell_filter #(
        .CYCLES (FILT_CYCLES)
    ) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_clr_i (off),
        .cond_i     (watch),
        .expired_o  (fire),
        .count_o    (dwell_cnt_o)
    );

    // Phase register: toggle on a completed dwell, drop when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || off) held_q <= 1'b0;
        else if (fire)     held_q <= !held_q;
    end

    assign reset_req_o     = held_q;
    assign release_phase_o = held_q;

endmodule

// File: rtl/sg_flag_ctrl.sv
// Module: sg_flag_ctrl
// Sticky low-voltage flag with software clear and interrupt gating.
// A set beats a clear in the same cycle. An active reset request wipes
// the flag and masks both outputs.
// Assumes detect_i is already synchronous to clk.
module sg_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic detect_i,
    input  logic clr_i,
    input  logic gie_i,
    input  logic reset_req_i,
    output logic flag_o,
    output logic irq_o
);

    logic flag_q;

    // Flag register: reset, then set, then software clear.
    always_ff @(posedge clk) begin
        if (!rst_n || reset_req_i) flag_q <= 1'b0;
        else if (detect_i)         flag_q <= 1'b1;
        else if (clr_i)            flag_q <= 1'b0;
    end

    // Output masking and interrupt gate.
    always_comb begin
        flag_o = flag_q && !reset_req_i;
        irq_o  = flag_o && gie_i;
    end

endmodule

// File: rtl/supply_guard.sv
// Module: supply_guard (top)
// Supply monitor controller: synchronizes the two comparator inputs,
// filters the reset comparator into a reset request with a release hold,
// and keeps the sticky low-voltage flag and interrupt.
// Assumes clk is a free-running low-frequency clock. FILT_CYCLES periods
// of it span the required dip filter time.
module supply_guard
    import supply_guard_pkg::*;
#(
    parameter int FILT_CYCLES = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       below_detect_i,
    input  logic       below_trip_i,
    input  logic [1:0] level_opt_i,
    input  logic       gie_i,
    input  logic       flag_clr_i,
    output logic       sys_reset_o,
    output logic [1:0] level_code_o,
    output logic       release_sel_o,
    output logic       lv_flag_o,
    output logic       lv_irq_o
);

    localparam int CW = $clog2(FILT_CYCLES + 1);

    logic [1:0]    comp_s;
    logic          det_s;
    logic          trip_s;
    lvl_code_e     code;
    logic [CW-1:0] dwell_cnt;

    sg_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({below_detect_i, below_trip_i}),
        .sync_o  (comp_s)
    );

    // Split the synchronized bits and type the option code.
    always_comb begin
        det_s  = comp_s[1];
        trip_s = comp_s[0];
        code   = lvl_code_e'(level_opt_i);
    end

    sg_reset_ctrl #(
        .FILT_CYCLES (FILT_CYCLES)
    ) u_rst (
        .clk             (clk),
        .rst_n           (rst_n),
        .below_i         (trip_s),
        .code_i          (code),
        .reset_req_o     (sys_reset_o),
        .release_phase_o (release_sel_o),
        .dwell_cnt_o     (dwell_cnt)
    );

    sg_flag_ctrl u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .detect_i    (det_s),
        .clr_i       (flag_clr_i),
        .gie_i       (gie_i),
        .reset_req_i (sys_reset_o),
        .flag_o      (lv_flag_o),
        .irq_o       (lv_irq_o)
    );

    assign level_code_o = level_opt_i;

endmodule

// File: rtl/sg_checker.sv
// Module: sg_checker
// Temporal properties of supply_guard, attached by bind below.
// Assumes the synchronized comparator bits and the dwell count are
// brought in from the top's internal nets.
module sg_checker #(
    parameter int FILT_CYCLES = 8,
    parameter int CW          = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    level_opt_i,
    input logic          gie_i,
    input logic          flag_clr_i,
    input logic          sys_reset_o,
    input logic          lv_flag_o,
    input logic          lv_irq_o,
    input logic          det_s,
    input logic          trip_s,
    input logic [CW-1:0] dwell_cnt
);

    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dwell_cnt < CW'(FILT_CYCLES));

    assert_rise_after_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_reset_o) |-> $past(trip_s));

    assert_fall_after_recover_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_reset_o) |-> (!$past(trip_s) || $past(level_opt_i) == 2'b11));

    assert_off_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (level_opt_i == 2'b11) |=> !sys_reset_o);

    assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lv_flag_o) |-> $past(det_s));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lv_flag_o && !flag_clr_i && !sys_reset_o) |=> (lv_flag_o || sys_reset_o));

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_i |-> !lv_irq_o);

    assert_quiet_in_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_o |-> (!lv_flag_o && !lv_irq_o));

endmodule

bind supply_guard sg_checker #(
    .FILT_CYCLES (FILT_CYCLES),
    .CW          (CW)
) u_sg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .level_opt_i (level_opt_i),
    .gie_i       (gie_i),
    .flag_clr_i  (flag_clr_i),
    .sys_reset_o (sys_reset_o),
    .lv_flag_o   (lv_flag_o),
    .lv_irq_o    (lv_irq_o),
    .det_s       (det_s),
    .trip_s      (trip_s),
    .dwell_cnt   (dwell_cnt)
);

// File: tb/supply_guard_bench.sv
// Bench for supply_guard: pulse-length sweeps on the trip input and a
// directed flag sequence. Inputs are driven and outputs sampled on the
// falling clock edge.
module supply_guard_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int S          = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       below_detect_i = 1'b0;
    logic       below_trip_i = 1'b0;
    logic [1:0] level_opt_i = 2'b00;
    logic       gie_i = 1'b0;
    logic       flag_clr_i = 1'b0;
    logic       sys_reset_o;
    logic [1:0] level_code_o;
    logic       release_sel_o;
    logic       lv_flag_o;
    logic       lv_irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    supply_guard #(.FILT_CYCLES(N), .SYNC_STAGES(S)) u_supply_guard (
        .clk            (clk),
        .rst_n          (rst_n),
        .below_detect_i (below_detect_i),
        .below_trip_i   (below_trip_i),
        .level_opt_i    (level_opt_i),
        .gie_i          (gie_i),
        .flag_clr_i     (flag_clr_i),
        .sys_reset_o    (sys_reset_o),
        .level_code_o   (level_code_o),
        .release_sel_o  (release_sel_o),
        .lv_flag_o      (lv_flag_o),
        .lv_irq_o       (lv_irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // One trip pulse of length len; measure the first high cycle and duration.
    task automatic trip_trial(input logic [1:0] code, input int len);
        int first = -1;
        int highs = 0;
        int sel_bad = 0;
        int leak = 0;
        int exp_first;
        int exp_highs;
        level_opt_i  = code;
        below_trip_i = 1'b1;
        for (int i = 1; i <= len + N + S + 4; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (sys_reset_o) begin
                highs++;
                if (first < 0) first = i;
                if (lv_flag_o || lv_irq_o) leak++;
            end
            if (release_sel_o != sys_reset_o) sel_bad++;
            if (i == len) below_trip_i = 1'b0;
        end
        if (code == 2'b11 || len < N) begin
            exp_first = -1;
            exp_highs = 0;
        end else begin
            exp_first = N + S;
            exp_highs = len;
        end
        if (code == 2'b11)   check("R5 reset held off", highs, 0);
        else if (len < N)    check("R2 short dip ignored", highs, 0);
        else                 check("R4 reset duration", highs, exp_highs);
        if (code != 2'b11 && len >= N) check("R3 first reset cycle", first, exp_first);
        check("R4 release select follows reset", sel_bad, 0);
        check("R10 flag/irq masked in reset", leak, 0);
        check("R5 level code passthrough", int'(level_code_o), int'(code));
        step(3);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R1 reset low", sys_reset_o, 0);
        check("R1 flag low", lv_flag_o, 0);
        check("R1 irq low", lv_irq_o, 0);

        // Flag set latency (R6, synchronizer depth).
        below_detect_i = 1'b1;
        step(S);
        check("R6 flag not yet set", lv_flag_o, 0);
        step(1);
        check("R6 flag set", lv_flag_o, 1);
        check("R9 irq off without enable", lv_irq_o, 0);
        gie_i = 1'b1;
        #1;
        check("R9 irq on with enable", lv_irq_o, 1);

        // Hardware fall leaves flag set (R7).
        below_detect_i = 1'b0;
        step(6);
        check("R7 flag sticky after detect falls", lv_flag_o, 1);
        flag_clr_i = 1'b1;
        step(1);
        flag_clr_i = 1'b0;
        check("R7 software clear", lv_flag_o, 0);
        check("R9 irq follows cleared flag", lv_irq_o, 0);

        // Set beats clear (R8).
        below_detect_i = 1'b1;
        step(S + 2);
        flag_clr_i = 1'b1;
        step(1);
        flag_clr_i = 1'b0;
        check("R8 set wins over clear", lv_flag_o, 1);

        // Trip sweeps with detect held high and the interrupt enabled.
        for (int c = 0; c < 4; c++) begin
            for (int len = 1; len <= N + 4; len++) begin
                trip_trial(2'(c), len);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule